// File: doc/BRIEF.md
# Multiplexed Address/Data Host Bus Slave

This block is the target side of a host bus in which one 16-bit set of lines carries first an address and then data. The host puts an address on the bus and pulses the address strobe. It then drops chip select together with either the read strobe or the write strobe, and holds them until the block pulls its ready line low. All host-side inputs arrive asynchronously. They are resynchronized to the master clock before any decision is made on them.

Inside the chip, the block exposes a narrow register port. In this project that port drives a small bank of registers: general-purpose scratch words, an interrupt status register whose bits are cleared by writing ones, and an interrupt mask. The active-low interrupt line toward the host is asserted while any status bit is both set and unmasked. The bus pads are modelled as split in/out/enable signals, so both the tri-state data drive and the tri-state ready line appear as explicit enables.

Top module: `hbus_slave`

## Requirements
- R1: After reset, rdyN is 1, rdyOe is 0, adOe is 0, intN is 1, and every scratch, status and mask register reads 16'h0000.
- R2: While aleIn is high, the address on adIn is captured. A following write strobe stores the adIn word at that address, and a later read of the same address returns it. Scratch words sit at addresses 0 to NUM_SCRATCH-1.
- R3: rdyN goes low on the fifth rising clock edge after csN and the strobe fall: two synchronizer stages, one accept cycle, then RDY_DELAY=2 wait cycles. It stays low while the strobe is held, and is back high by the third rising edge after the strobe is released.
- R4: rdyOe is high exactly when the once-registered csN is low. The ready line is therefore undriven from the first rising edge after csN rises.
- R5: During a read, adOut carries the addressed register and adOe is high while csN and rdN stay low. adOe falls on the first rising edge after either of them rises.
- R6: A write to an unmapped address changes no register. A read from an unmapped address returns 16'h0000.
- R7: Status bits (address 16'h0010, low IRQ_W bits) are set by a high level on the matching irqSrc bit. A written 1 clears a bit and a written 0 leaves it unchanged. When a set and a clear land in the same cycle, the set wins.
- R8: intN is low exactly when status AND mask (mask at address 16'h0011, low IRQ_W bits) is non-zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| adIn | input | AD_W | Address/data bus as seen from the pad |
| adOut | output | AD_W | Read data toward the pad |
| adOe | output | 1 | Pad drive enable for adOut |
| aleIn | input | 1 | Address latch strobe, active high |
| csN | input | 1 | Chip select, active low |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| rdyN | output | 1 | Cycle-ready, active low |
| rdyOe | output | 1 | Pad drive enable for rdyN |
| intN | output | 1 | Interrupt request, active low |
| irqSrc | input | IRQ_W | On-chip interrupt sources, synchronous to clk |

## Verification
The assertions assume that the host behaves as a well-formed bus master. It holds the address steady for the two synchronizer cycles around the strobe's fall, keeps the strobe low until ready is seen, and never lowers read and write in the same cycle. They also assume that irqSrc is synchronous to the master clock. The stimulus drives every host pin at the falling clock edge. It holds the address and data a full cycle beyond each strobe, waits for ready before releasing, and leaves at least three idle cycles between transactions, so no accept can overlap the previous one.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_READY = 2'd2
  } cycState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchAddr;
    logic wrEn;
    logic rdEn;
  } hostStrobe_t;
endpackage

// File: rtl/hbus_ctrl.sv
module hbus_ctrl
  import hbus_pkg::*;
#(
  parameter int RDY_DELAY = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        aleIn,
  input  logic        csN,
  input  logic        rdN,
  input  logic        wrN,
  output hostStrobe_t strb,
  output logic        adOe,
  output logic        rdyN,
  output logic        rdyOe
);
  localparam int CNT_W = (RDY_DELAY < 2) ? 1 : $clog2(RDY_DELAY);

  logic [1:0] aleSync, csSync, rdSync, wrSync;
  logic       ale2, cs1, cs2, rd1, rd2, wr2;
  logic       valid;
  cycState_t  state;
  logic [CNT_W-1:0] waitCnt;
  logic       readActive;

  // two-stage synchronizers; strobes idle high, latch idle low
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aleSync <= 2'b00;
      csSync  <= 2'b11;
      rdSync  <= 2'b11;
      wrSync  <= 2'b11;
    end else begin
      aleSync <= {aleSync[0], aleIn};
      csSync  <= {csSync[0], csN};
      rdSync  <= {rdSync[0], rdN};
      wrSync  <= {wrSync[0], wrN};
    end
  end

  assign ale2 = aleSync[1];
  assign cs1  = csSync[0];
  assign cs2  = csSync[1];
  assign rd1  = rdSync[0];
  assign rd2  = rdSync[1];
  assign wr2  = wrSync[1];

  assign valid = !cs2 && (!rd2 || !wr2);

  always_comb begin
    strb           = '0;
    strb.latchAddr = ale2;
    strb.wrEn      = (state == ST_IDLE) && valid && !wr2;
    strb.rdEn      = (state == ST_IDLE) && valid && wr2;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      waitCnt    <= '0;
      readActive <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (valid) begin
            state   <= ST_WAIT;
            waitCnt <= CNT_W'(RDY_DELAY - 1);
          end
          if (strb.rdEn) readActive <= 1'b1;
        end
        ST_WAIT: begin
          if (waitCnt == '0) state <= ST_READY;
          else               waitCnt <= waitCnt - 1'b1;
        end
        ST_READY: begin
          if (!valid) begin
            state      <= ST_IDLE;
            readActive <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign adOe  = readActive && !cs1 && !rd1;
  assign rdyN  = (state != ST_READY);
  assign rdyOe = !cs1;
endmodule

// File: rtl/hbus_datapath.sv
module hbus_datapath
  import hbus_pkg::*;
#(
  parameter int AD_W        = 16,
  parameter int IRQ_W       = 8,
  parameter int NUM_SCRATCH = 4,
  parameter logic [AD_W-1:0] STATUS_ADDR = 16'h0010,
  parameter logic [AD_W-1:0] MASK_ADDR   = 16'h0011
) (
  input  logic             clk,
  input  logic             rstN,
  input  hostStrobe_t      strb,
  input  logic [AD_W-1:0]  adIn,
  input  logic [IRQ_W-1:0] irqSrc,
  output logic [AD_W-1:0]  adOut,
  output logic             intN,
  output logic [IRQ_W-1:0] statusBits,
  output logic [IRQ_W-1:0] maskBits
);
  logic [AD_W-1:0]  adS1, adS2;
  logic [AD_W-1:0]  addrReg;
  logic [AD_W-1:0]  scratch [NUM_SCRATCH];
  logic [AD_W-1:0]  rdMux, rdData;
  logic [IRQ_W-1:0] clrBits;

  // bus data follows the same two-stage path as the strobes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      adS1    <= '0;
      adS2    <= '0;
      addrReg <= '0;
    end else begin
      adS1 <= adIn;
      adS2 <= adS1;
      if (strb.latchAddr) addrReg <= adS2;
    end
  end

  for (genvar g = 0; g < NUM_SCRATCH; g++) begin : gScratch
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                         scratch[g] <= '0;
      else if (strb.wrEn && (addrReg == AD_W'(g)))       scratch[g] <= adS2;
    end
  end

  assign clrBits = (strb.wrEn && (addrReg == STATUS_ADDR)) ? adS2[IRQ_W-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusBits <= '0;
      maskBits   <= '0;
    end else begin
      statusBits <= (statusBits & ~clrBits) | irqSrc;
      if (strb.wrEn && (addrReg == MASK_ADDR)) maskBits <= adS2[IRQ_W-1:0];
    end
  end

  always_comb begin
    rdMux = '0;
    for (int i = 0; i < NUM_SCRATCH; i++)
      if (addrReg == AD_W'(i)) rdMux = scratch[i];
    if (addrReg == STATUS_ADDR) rdMux[IRQ_W-1:0] = statusBits;
    if (addrReg == MASK_ADDR)   rdMux[IRQ_W-1:0] = maskBits;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          rdData <= '0;
    else if (strb.rdEn) rdData <= rdMux;
  end

  assign adOut = rdData;
  assign intN  = ~|(statusBits & maskBits);
endmodule

// File: rtl/hbus_slave.sv
module hbus_slave
  import hbus_pkg::*;
#(
  parameter int AD_W        = 16,
  parameter int IRQ_W       = 8,
  parameter int NUM_SCRATCH = 4,
  parameter int RDY_DELAY   = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [AD_W-1:0]  adIn,
  output logic [AD_W-1:0]  adOut,
  output logic             adOe,
  input  logic             aleIn,
  input  logic             csN,
  input  logic             rdN,
  input  logic             wrN,
  output logic             rdyN,
  output logic             rdyOe,
  output logic             intN,
  input  logic [IRQ_W-1:0] irqSrc
);
  hostStrobe_t      strb;
  logic [IRQ_W-1:0] statusBits, maskBits;

  hbus_ctrl #(.RDY_DELAY(RDY_DELAY)) u_ctrl (
    .clk(clk), .rstN(rstN), .aleIn(aleIn), .csN(csN), .rdN(rdN), .wrN(wrN),
    .strb(strb), .adOe(adOe), .rdyN(rdyN), .rdyOe(rdyOe)
  );

  hbus_datapath #(
    .AD_W(AD_W), .IRQ_W(IRQ_W), .NUM_SCRATCH(NUM_SCRATCH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .adIn(adIn), .irqSrc(irqSrc),
    .adOut(adOut), .intN(intN), .statusBits(statusBits), .maskBits(maskBits)
  );
endmodule

// File: rtl/hbus_slave_chk.sv
module hbus_slave_chk
  import hbus_pkg::*;
#(
  parameter int IRQ_W     = 8,
  parameter int RDY_DELAY = 2
) (
  input logic             clk,
  input logic             rstN,
  input hostStrobe_t      strb,
  input logic             rdyN,
  input logic             adOe,
  input logic             intN,
  input logic [IRQ_W-1:0] statusBits,
  input logic [IRQ_W-1:0] maskBits
);
  logic [7:0] sinceAcc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          sinceAcc <= '0;
    else if (strb.wrEn || strb.rdEn)    sinceAcc <= 8'd1;
    else if (sinceAcc != 8'hFF)         sinceAcc <= sinceAcc + 8'd1;
  end

  p_ready_latency_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdyN) |-> (sinceAcc == 8'(RDY_DELAY + 1)));

  p_no_accept_in_ready_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn || strb.rdEn) |-> rdyN);

  p_single_access_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrEn, strb.rdEn}));

  p_drive_after_read_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(adOe) |-> $past(strb.rdEn));

  p_int_needs_change_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(intN) |-> (statusBits != $past(statusBits) || maskBits != $past(maskBits)));
endmodule

bind hbus_slave hbus_slave_chk #(.IRQ_W(IRQ_W), .RDY_DELAY(RDY_DELAY)) u_chk (
  .clk(clk), .rstN(rstN), .strb(strb), .rdyN(rdyN), .adOe(adOe), .intN(intN),
  .statusBits(statusBits), .maskBits(maskBits)
);

// File: tb/hbus_slave_tb.sv
module hbus_slave_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] adIn = '0;
  logic [15:0] adOut;
  logic        adOe, rdyN, rdyOe, intN;
  logic        aleIn = 1'b0, csN = 1'b1, rdN = 1'b1, wrN = 1'b1;
  logic [7:0]  irqSrc = '0;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;
  logic [15:0] expQ[$];
  string       tagQ[$];
  logic        prevRdyN = 1'b1;

  always #2 clk = ~clk;

  hbus_slave u_dut (
    .clk(clk), .rstN(rstN), .adIn(adIn), .adOut(adOut), .adOe(adOe),
    .aleIn(aleIn), .csN(csN), .rdN(rdN), .wrN(wrN), .rdyN(rdyN),
    .rdyOe(rdyOe), .intN(intN), .irqSrc(irqSrc)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic addrPhase(logic [15:0] a);
    @(negedge clk); adIn = a; aleIn = 1'b1;
    repeat (2) @(negedge clk);
    aleIn = 1'b0;
    @(negedge clk);
  endtask

  // wait for ready, return the number of falling edges it took
  task automatic waitReady(output int lat);
    lat = 0;
    for (int i = 1; i <= 20; i++) begin
      @(negedge clk);
      if (!rdyN) begin lat = i; break; end
    end
  endtask

  task automatic hostWrite(logic [15:0] a, logic [15:0] d);
    int lat;
    addrPhase(a);
    adIn = d; csN = 1'b0; wrN = 1'b0;
    waitReady(lat);
    check(lat == 5, "R3", "write ready latency", lat, 5);
    check(rdyOe == 1'b1, "R4", "ready driven while selected", rdyOe, 1);
    @(negedge clk);
    check(rdyN == 1'b0, "R3", "ready held", rdyN, 0);
    wrN = 1'b1; csN = 1'b1;
    @(negedge clk);
    check(rdyOe == 1'b0, "R4", "ready released after deselect", rdyOe, 0);
    repeat (2) @(negedge clk);
    check(rdyN == 1'b1, "R3", "ready high after release", rdyN, 1);
  endtask

  // driver: pushes the expected word, the monitor compares it
  task automatic hostRead(logic [15:0] a, logic [15:0] exp, string tag);
    int lat;
    addrPhase(a);
    expQ.push_back(exp); tagQ.push_back(tag);
    csN = 1'b0; rdN = 1'b0;
    waitReady(lat);
    check(lat == 5, "R3", "read ready latency", lat, 5);
    @(negedge clk);
    check(adOe == 1'b1, "R5", "bus driven during read", adOe, 1);
    rdN = 1'b1;
    @(negedge clk);
    check(adOe == 1'b0, "R5", "bus released one clock after strobe", adOe, 0);
    csN = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (prevRdyN && !rdyN && adOe) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R5", "unexpected read data", adOut, 0);
      end else begin
        logic [15:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(adOut == e, t, "read data", adOut, e);
      end
    end
    prevRdyN <= rdyN;
  end

  task automatic pulseIrq(logic [7:0] v);
    @(negedge clk); irqSrc = v;
    @(negedge clk); irqSrc = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(rdyN == 1'b1, "R1", "rdyN after reset", rdyN, 1);
    check(rdyOe == 1'b0, "R1", "rdyOe after reset", rdyOe, 0);
    check(adOe == 1'b0, "R1", "adOe after reset", adOe, 0);
    check(intN == 1'b1, "R1", "intN after reset", intN, 1);
    hostRead(16'h0000, 16'h0000, "R1");
    hostRead(16'h0010, 16'h0000, "R1");
    hostRead(16'h0011, 16'h0000, "R1");

    // R2: write then read back, several patterns
    hostWrite(16'h0000, 16'hA5C3);
    hostWrite(16'h0001, 16'hFFFF);
    hostWrite(16'h0002, 16'h0001);
    hostWrite(16'h0003, 16'h8000);
    hostRead(16'h0003, 16'h8000, "R2");
    hostRead(16'h0000, 16'hA5C3, "R2");
    hostRead(16'h0002, 16'h0001, "R2");
    hostRead(16'h0001, 16'hFFFF, "R2");

    // R6: unmapped write ignored, unmapped read zero
    hostWrite(16'h0100, 16'h1234);
    hostWrite(16'h0004, 16'h5678);
    hostRead(16'h0100, 16'h0000, "R6");
    hostRead(16'h0004, 16'h0000, "R6");
    hostRead(16'h0000, 16'hA5C3, "R6");
    hostRead(16'h0003, 16'h8000, "R6");

    // R7/R8: status, mask, interrupt
    pulseIrq(8'h05);
    @(negedge clk);
    check(intN == 1'b1, "R8", "masked status keeps intN high", intN, 1);
    hostRead(16'h0010, 16'h0005, "R7");
    hostWrite(16'h0011, 16'h0004);
    check(intN == 1'b0, "R8", "unmasked bit drives intN low", intN, 0);
    hostWrite(16'h0010, 16'h0000);
    hostRead(16'h0010, 16'h0005, "R7");
    hostWrite(16'h0010, 16'h0001);
    hostRead(16'h0010, 16'h0004, "R7");
    check(intN == 1'b0, "R8", "intN stays low with bit 2 set", intN, 0);
    hostWrite(16'h0010, 16'h0004);
    hostRead(16'h0010, 16'h0000, "R7");
    check(intN == 1'b1, "R8", "intN high after clear", intN, 1);
    pulseIrq(8'h01);
    @(negedge clk);
    check(intN == 1'b1, "R8", "bit outside mask", intN, 1);
    hostRead(16'h0011, 16'h0004, "R8");

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R5", "reads left unmatched", expQ.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL R3 watchdog expired: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule